// File: doc/BRIEF.md
# Opcode Prefix Decoder and Classifier

This block sits behind the instruction-fetch stage of an 8-bit processor core that uses shift-prefix bytes (CB, DD, ED, FD). It accepts one opcode byte per strobe and follows the prefix state across bytes. For every finished instruction, and for every prefix that is overridden before it can take effect, it emits one registered record one clock after the byte that finishes it. The record gives the prefix group, the final opcode byte, which 16-bit pair stands in for HL, whether that pair is used by halves, whether a signed displacement byte belongs to the instruction, and a classification of the ED page.

The stream carries opcode bytes only. Operand and displacement bytes are skipped by the fetch unit, using the record. There is one exception: in the doubly prefixed index-bit forms, the displacement byte sits between the CB byte and the final opcode. It is therefore fed to the decoder and returned inside the record. Undefined ED codes are folded onto their canonical equivalents or marked as fixed-cost no-ops. Prefixes that are overridden are reported with a fixed 4-cycle cost, so that a timing model can charge them.

Top module: `opx_decoder`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `rec_valid` is 0. Reset discards any prefix already received, so the next byte decodes as unprefixed.
- R2: In the idle state, a byte other than CB/DD/ED/FD yields one record one clock after its strobe. That record has group NONE (0), the byte as opcode, select HL (0), half 0, displacement 0, drop 0, edkind 0, canon equal to the opcode, and fixed cost 0.
- R3: After DD (group 3, select IX=1) or FD (group 4, select IY=2), an opcode that uses the HL pair reports the index select. The pair uses are 09/19/29/39, 21, 22, 2A, 23, 2B, E1, E3, E5, E9 and F9.
- R4: After DD/FD, an opcode that reaches memory through HL reports displacement 1 with the index select. These are 34, 35, 36, 40–7F with source or destination field 6 except 76, and 80–BF with source field 6. Opcode 76 reports select HL and displacement 0.
- R5: After DD/FD, an opcode that names H or L on its own, and not through memory, reports half 1 with the index select. In an opcode that also reaches memory, H/L stay plain (half 0).
- R6: After DD/FD, an opcode that touches none of HL, H, L or (HL) reports select HL, half 0 and displacement 0, with group DD/FD.
- R7: A DD/FD byte that follows DD/FD yields a record for the earlier prefix: drop 1, its own group and byte, and fixed cost 4. Only the last index prefix selects the register.
- R8: A prefix byte that follows DD/FD or ED emits a drop record for the earlier prefix (ED: group 2, opcode ED, cost 4), and decoding restarts at the new prefix. CB after DD/FD is the exception, because it starts the doubly prefixed form.
- R9: DD CB d op and FD CB d op yield exactly one record, after the fourth byte. It carries group 5 (DD) or 6 (FD), opcode op, displacement 1, the byte d, and select IX/IY.
- R10: `rec_sll` is 1 exactly when the group is CB, 5 or 6 and the opcode lies in 30–37.
- R11: After ED, codes 00–3F and 80–FF other than A0–A3, A8–AB, B0–B3 and B8–BB give edkind NOP8 (2), canon 00 and cost 8. The listed block codes give edkind DEF (1) with canon equal to the opcode.
- R12: After ED, 4C/54/5C/64/6C/74/7C give edkind ALIAS (3) with canon 44. 55/5D/65/6D/75/7D give ALIAS with canon 45. 66, 76 and 7E give ALIAS with canons 46, 56 and 5E. Other defined codes in 40–7F give DEF.
- R13: ED 70 gives edkind IN_FLAGS (4), a port read that sets flags and discards the data. ED 71 gives OUT_ZERO (5), which writes zero to the port addressed by C. ED 77 and 7F give NOP8 with canon 00 and cost 8.
- R14: A byte presented while `byte_valid` is 0 has no effect on the state or on any record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | Strobe: `byte_data` carries an opcode-stream byte |
| byte_data | input | 8 | Opcode-stream byte |
| rec_valid | output | 1 | One-cycle pulse: record fields are valid |
| rec_group | output | 3 | 0 none, 1 CB, 2 ED, 3 DD, 4 FD, 5 DDCB, 6 FDCB |
| rec_opcode | output | 8 | Final opcode byte (or the dropped prefix byte) |
| rec_sel | output | 2 | Pair standing for HL: 0 HL, 1 IX, 2 IY |
| rec_half | output | 1 | H/L operands map to the index halves |
| rec_disp | output | 1 | A signed displacement belongs to this instruction |
| rec_disp_byte | output | 8 | Displacement captured in the doubly prefixed forms, else 0 |
| rec_sll | output | 1 | Shift-left-set-bit-0 group |
| rec_edkind | output | 3 | 0 n/a, 1 DEF, 2 NOP8, 3 ALIAS, 4 IN_FLAGS, 5 OUT_ZERO |
| rec_canon | output | 8 | Canonical opcode after alias folding |
| rec_dropped | output | 1 | Record reports a prefix that was overridden |
| rec_fixed_t | output | T_W | Fixed T-state cost (4 dropped prefix, 8 ED no-op, else 0) |

## Verification
Unprefixed bytes, with idle gaps whose data lines carry prefix values, show that only strobed bytes advance the decoder. Single DD/FD prefixes in front of pair, memory, half-register and unrelated opcodes separate the four substitution outcomes, and 76 with DD catches a memory rule that is too broad. Chained and mixed prefixes (DD FD DD, DD ED, ED FD) check that the earlier prefix is dropped and that the last one wins. The doubly prefixed form checks that the displacement is captured and that only one record is produced. ED sweeps over block codes, undefined codes, every alias family and the 70/71/77 specials separate the no-op, alias and defined outcomes.

// File: rtl/opx_pkg.sv
package opx_pkg;
  localparam int OP_W = 8;

  localparam logic [OP_W-1:0] PFX_CB = 8'hCB;
  localparam logic [OP_W-1:0] PFX_DD = 8'hDD;
  localparam logic [OP_W-1:0] PFX_ED = 8'hED;
  localparam logic [OP_W-1:0] PFX_FD = 8'hFD;

  typedef enum logic [2:0] {
    GRP_NONE = 3'd0,
    GRP_CB   = 3'd1,
    GRP_ED   = 3'd2,
    GRP_DD   = 3'd3,
    GRP_FD   = 3'd4,
    GRP_DDCB = 3'd5,
    GRP_FDCB = 3'd6
  } grp_e;

  typedef enum logic [1:0] {
    SEL_HL = 2'd0,
    SEL_IX = 2'd1,
    SEL_IY = 2'd2
  } sel_e;

  typedef enum logic [2:0] {
    EDK_NA       = 3'd0,
    EDK_DEF      = 3'd1,
    EDK_NOP8     = 3'd2,
    EDK_ALIAS    = 3'd3,
    EDK_IN_FLAGS = 3'd4,
    EDK_OUT_ZERO = 3'd5
  } edk_e;
endpackage

// File: rtl/opx_pfx_fsm.sv
module opx_pfx_fsm
  import opx_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            in_vld,
  input  logic [OP_W-1:0] in_byte,
  output logic            ev_vld,
  output logic            ev_drop,
  output grp_e            ev_grp,
  output logic [OP_W-1:0] ev_op,
  output logic [OP_W-1:0] ev_dbyte,
  output sel_e            ev_idx
);
  typedef enum logic [2:0] {
    S_IDLE, S_IDX, S_ED, S_CB, S_XD, S_XOP
  } st_e;

  st_e             st_q, st_d;
  sel_e            idx_q, idx_d;
  logic [OP_W-1:0] disp_q, disp_d;

  logic            is_pfx;
  st_e             pfx_st;
  sel_e            pfx_idx;
  grp_e            idx_grp;
  logic [OP_W-1:0] idx_byte;

  // Where a prefix byte leads, and which index it names
  always_comb begin
    is_pfx   = (in_byte == PFX_CB) || (in_byte == PFX_ED) ||
               (in_byte == PFX_DD) || (in_byte == PFX_FD);
    pfx_st   = (in_byte == PFX_CB) ? S_CB :
               (in_byte == PFX_ED) ? S_ED : S_IDX;
    pfx_idx  = (in_byte == PFX_FD) ? SEL_IY : SEL_IX;
    idx_grp  = (idx_q == SEL_IY) ? GRP_FD : GRP_DD;
    idx_byte = (idx_q == SEL_IY) ? PFX_FD : PFX_DD;
  end

  always_comb begin
    st_d     = st_q;
    idx_d    = idx_q;
    disp_d   = disp_q;
    ev_vld   = 1'b0;
    ev_drop  = 1'b0;
    ev_grp   = GRP_NONE;
    ev_op    = in_byte;
    ev_dbyte = '0;
    ev_idx   = SEL_HL;
    if (in_vld) begin
      case (st_q)
        S_IDLE: begin
          if (is_pfx) begin
            st_d = pfx_st;
            if (pfx_st == S_IDX) idx_d = pfx_idx;
          end else begin
            ev_vld = 1'b1;
          end
        end
        S_IDX: begin
          if (in_byte == PFX_CB) begin
            st_d = S_XD;
          end else if (is_pfx) begin
            ev_vld  = 1'b1;
            ev_drop = 1'b1;
            ev_grp  = idx_grp;
            ev_op   = idx_byte;
            st_d    = pfx_st;
            if (pfx_st == S_IDX) idx_d = pfx_idx;
          end else begin
            ev_vld = 1'b1;
            ev_grp = idx_grp;
            ev_idx = idx_q;
            st_d   = S_IDLE;
          end
        end
        S_ED: begin
          ev_vld = 1'b1;
          ev_grp = GRP_ED;
          if (is_pfx) begin
            ev_drop = 1'b1;
            ev_op   = PFX_ED;
            st_d    = pfx_st;
            if (pfx_st == S_IDX) idx_d = pfx_idx;
          end else begin
            st_d = S_IDLE;
          end
        end
        S_CB: begin
          ev_vld = 1'b1;
          ev_grp = GRP_CB;
          st_d   = S_IDLE;
        end
        S_XD: begin
          disp_d = in_byte;
          st_d   = S_XOP;
        end
        S_XOP: begin
          ev_vld   = 1'b1;
          ev_grp   = (idx_q == SEL_IY) ? GRP_FDCB : GRP_DDCB;
          ev_idx   = idx_q;
          ev_dbyte = disp_q;
          st_d     = S_IDLE;
        end
        default: st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= S_IDLE;
      idx_q  <= SEL_IX;
      disp_q <= '0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      disp_q <= disp_d;
    end
  end
endmodule

// File: rtl/opx_idx_class.sv
module opx_idx_class
  import opx_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output logic            uses_pair,
  output logic            uses_half,
  output logic            uses_mem
);
  logic [1:0] x, p;
  logic [2:0] y, z;
  logic       q, y_h, z_h;

  always_comb begin
    x   = op[7:6];
    y   = op[5:3];
    z   = op[2:0];
    p   = op[5:4];
    q   = op[3];
    y_h = (y == 3'd4) || (y == 3'd5);
    z_h = (z == 3'd4) || (z == 3'd5);
    uses_pair = 1'b0;
    uses_half = 1'b0;
    uses_mem  = 1'b0;
    case (x)
      2'd0: begin
        // 16-bit loads, adds and inc/dec naming the HL pair
        if (z == 3'd1 && (p == 2'd2 || q)) uses_pair = 1'b1;
        if ((z == 3'd2 || z == 3'd3) && p == 2'd2) uses_pair = 1'b1;
        // 8-bit inc/dec/load-immediate
        if (z == 3'd4 || z == 3'd5 || z == 3'd6) begin
          if (y == 3'd6) uses_mem = 1'b1;
          else if (y_h)  uses_half = 1'b1;
        end
      end
      2'd1: begin
        if (op != 8'h76) begin
          if (y == 3'd6 || z == 3'd6) uses_mem = 1'b1;
          else if (y_h || z_h)        uses_half = 1'b1;
        end
      end
      2'd2: begin
        if (z == 3'd6)  uses_mem = 1'b1;
        else if (z_h)   uses_half = 1'b1;
      end
      default: begin
        if (op == 8'hE1 || op == 8'hE3 || op == 8'hE5 ||
            op == 8'hE9 || op == 8'hF9)
          uses_pair = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/opx_ed_class.sv
module opx_ed_class
  import opx_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output edk_e            kind,
  output logic [OP_W-1:0] canon
);
  logic [2:0] y, z;
  logic       mid, blk;

  always_comb begin
    y     = op[5:3];
    z     = op[2:0];
    mid   = (op[7:6] == 2'b01);
    blk   = (op[7:5] == 3'b101) && !op[2];
    kind  = EDK_DEF;
    canon = op;
    if (mid) begin
      if (op == 8'h70) begin
        kind = EDK_IN_FLAGS;
      end else if (op == 8'h71) begin
        kind = EDK_OUT_ZERO;
      end else if (z == 3'd4 && y != 3'd0) begin
        kind  = EDK_ALIAS;
        canon = 8'h44;
      end else if (z == 3'd5 && y > 3'd1) begin
        kind  = EDK_ALIAS;
        canon = 8'h45;
      end else if (op == 8'h66) begin
        kind  = EDK_ALIAS;
        canon = 8'h46;
      end else if (op == 8'h76) begin
        kind  = EDK_ALIAS;
        canon = 8'h56;
      end else if (op == 8'h7E) begin
        kind  = EDK_ALIAS;
        canon = 8'h5E;
      end else if (z == 3'd7 && y >= 3'd6) begin
        kind  = EDK_NOP8;
        canon = '0;
      end
    end else if (!blk) begin
      kind  = EDK_NOP8;
      canon = '0;
    end
  end
endmodule

// File: rtl/opx_decoder.sv
module opx_decoder
  import opx_pkg::*;
#(
  parameter int PFX_NOP_T = 4,
  parameter int ED_NOP_T  = 8,
  parameter int T_W       = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           byte_valid,
  input  logic [7:0]     byte_data,
  output logic           rec_valid,
  output logic [2:0]     rec_group,
  output logic [7:0]     rec_opcode,
  output logic [1:0]     rec_sel,
  output logic           rec_half,
  output logic           rec_disp,
  output logic [7:0]     rec_disp_byte,
  output logic           rec_sll,
  output logic [2:0]     rec_edkind,
  output logic [7:0]     rec_canon,
  output logic           rec_dropped,
  output logic [T_W-1:0] rec_fixed_t
);
  localparam logic [T_W-1:0] PFX_COST = T_W'(PFX_NOP_T);
  localparam logic [T_W-1:0] EDN_COST = T_W'(ED_NOP_T);

  logic            ev_vld, ev_drop;
  grp_e            ev_grp;
  logic [OP_W-1:0] ev_op, ev_dbyte;
  sel_e            ev_idx;
  logic            c_pair, c_half, c_mem;
  edk_e            e_kind;
  logic [OP_W-1:0] e_canon;

  opx_pfx_fsm u_fsm (
    .clk(clk), .rst(rst), .in_vld(byte_valid), .in_byte(byte_data),
    .ev_vld(ev_vld), .ev_drop(ev_drop), .ev_grp(ev_grp), .ev_op(ev_op),
    .ev_dbyte(ev_dbyte), .ev_idx(ev_idx)
  );

  opx_idx_class u_idx (
    .op(ev_op), .uses_pair(c_pair), .uses_half(c_half), .uses_mem(c_mem)
  );

  opx_ed_class u_ed (
    .op(ev_op), .kind(e_kind), .canon(e_canon)
  );

  logic            n_sll, n_half, n_disp;
  sel_e            n_sel;
  edk_e            n_kind;
  logic [OP_W-1:0] n_canon;
  logic [T_W-1:0]  n_ft;
  logic            sll_code;

  always_comb begin
    sll_code = (ev_op[7:3] == 5'b00110);
    n_sel    = SEL_HL;
    n_half   = 1'b0;
    n_disp   = 1'b0;
    n_sll    = 1'b0;
    n_kind   = EDK_NA;
    n_canon  = ev_op;
    n_ft     = '0;
    if (ev_drop) begin
      n_ft = PFX_COST;
    end else begin
      case (ev_grp)
        GRP_CB: n_sll = sll_code;
        GRP_ED: begin
          n_kind  = e_kind;
          n_canon = e_canon;
          if (e_kind == EDK_NOP8) n_ft = EDN_COST;
        end
        GRP_DD, GRP_FD: begin
          if (c_pair || c_half || c_mem) n_sel = ev_idx;
          n_half = c_half;
          n_disp = c_mem;
        end
        GRP_DDCB, GRP_FDCB: begin
          n_sel  = ev_idx;
          n_disp = 1'b1;
          n_sll  = sll_code;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rec_valid     <= 1'b0;
      rec_group     <= '0;
      rec_opcode    <= '0;
      rec_sel       <= '0;
      rec_half      <= 1'b0;
      rec_disp      <= 1'b0;
      rec_disp_byte <= '0;
      rec_sll       <= 1'b0;
      rec_edkind    <= '0;
      rec_canon     <= '0;
      rec_dropped   <= 1'b0;
      rec_fixed_t   <= '0;
    end else begin
      rec_valid <= ev_vld;
      if (ev_vld) begin
        rec_group     <= ev_grp;
        rec_opcode    <= ev_op;
        rec_sel       <= n_sel;
        rec_half      <= n_half;
        rec_disp      <= n_disp;
        rec_disp_byte <= ev_dbyte;
        rec_sll       <= n_sll;
        rec_edkind    <= n_kind;
        rec_canon     <= n_canon;
        rec_dropped   <= ev_drop;
        rec_fixed_t   <= n_ft;
      end
    end
  end
endmodule

// File: rtl/opx_decoder_chk.sv
module opx_decoder_chk #(
  parameter int PFX_NOP_T = 4,
  parameter int ED_NOP_T  = 8,
  parameter int T_W       = 5
) (
  input logic           clk,
  input logic           rst,
  input logic           byte_valid,
  input logic           rec_valid,
  input logic [2:0]     rec_group,
  input logic [7:0]     rec_opcode,
  input logic [1:0]     rec_sel,
  input logic           rec_half,
  input logic           rec_disp,
  input logic           rec_sll,
  input logic [2:0]     rec_edkind,
  input logic           rec_dropped,
  input logic [T_W-1:0] rec_fixed_t
);
  p_rec_needs_strobe_r14: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> $past(byte_valid));

  p_plain_record_r2: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && rec_group == 3'd0) |->
      (rec_sel == 2'd0 && !rec_disp && !rec_half && !rec_dropped && rec_edkind == 3'd0));

  p_sel_legal_r3: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> (rec_sel != 2'd3 && rec_group <= 3'd6));

  p_half_not_mem_r5: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && rec_half) |-> (!rec_disp && rec_sel != 2'd0));

  p_drop_cost_r7: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && rec_dropped) |->
      (rec_fixed_t == T_W'(PFX_NOP_T) && (rec_group == 3'd2 || rec_group == 3'd3 || rec_group == 3'd4)));

  p_xcb_disp_r9: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && (rec_group == 3'd5 || rec_group == 3'd6)) |->
      (rec_disp && rec_sel != 2'd0));

  p_sll_scope_r10: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && rec_sll) |->
      ((rec_group == 3'd1 || rec_group == 3'd5 || rec_group == 3'd6) && rec_opcode[7:3] == 5'b00110));

  p_ednop_cost_r11: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && rec_edkind == 3'd2) |->
      (rec_fixed_t == T_W'(ED_NOP_T) && rec_group == 3'd2));
endmodule

bind opx_decoder opx_decoder_chk #(
  .PFX_NOP_T(PFX_NOP_T), .ED_NOP_T(ED_NOP_T), .T_W(T_W)
) u_chk (
  .clk(clk), .rst(rst), .byte_valid(byte_valid), .rec_valid(rec_valid),
  .rec_group(rec_group), .rec_opcode(rec_opcode), .rec_sel(rec_sel),
  .rec_half(rec_half), .rec_disp(rec_disp), .rec_sll(rec_sll),
  .rec_edkind(rec_edkind), .rec_dropped(rec_dropped), .rec_fixed_t(rec_fixed_t)
);

// File: tb/test_opx_decoder.sv
`timescale 1ns/1ps
module test_opx_decoder;
  localparam int T_W = 5;
  localparam int REC_W = 3 + 8 + 2 + 1 + 1 + 8 + 1 + 3 + 8 + 1 + T_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic byte_valid = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic rec_valid, rec_half, rec_disp, rec_sll, rec_dropped;
  logic [2:0] rec_group, rec_edkind;
  logic [7:0] rec_opcode, rec_disp_byte, rec_canon;
  logic [1:0] rec_sel;
  logic [T_W-1:0] rec_fixed_t;

  always #10 clk = ~clk;

  opx_decoder #(.T_W(T_W)) i_opx_decoder (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_data(byte_data),
    .rec_valid(rec_valid), .rec_group(rec_group), .rec_opcode(rec_opcode),
    .rec_sel(rec_sel), .rec_half(rec_half), .rec_disp(rec_disp),
    .rec_disp_byte(rec_disp_byte), .rec_sll(rec_sll), .rec_edkind(rec_edkind),
    .rec_canon(rec_canon), .rec_dropped(rec_dropped), .rec_fixed_t(rec_fixed_t)
  );

  typedef struct {
    string            tag;
    logic [REC_W-1:0] v;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;

  // field order: group, opcode, sel, half, disp, dbyte, sll, edkind, canon, drop, cost
  task automatic exp_rec(input string tag, input logic [2:0] g, input logic [7:0] op,
                         input logic [1:0] sel, input logic hf, input logic dp,
                         input logic [7:0] db, input logic sl, input logic [2:0] k,
                         input logic [7:0] cn, input logic dr, input logic [T_W-1:0] ft);
    exp_t e;
    e.tag = tag;
    e.v = {g, op, sel, hf, dp, db, sl, k, cn, dr, ft};
    exp_q.push_back(e);
  endtask

  task automatic e_none(input string tag, input logic [7:0] op);
    exp_rec(tag, 3'd0, op, 2'd0, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0, op, 1'b0, 5'd0);
  endtask
  task automatic e_idx(input string tag, input logic [2:0] g, input logic [7:0] op,
                       input logic [1:0] sel, input logic hf, input logic dp);
    exp_rec(tag, g, op, sel, hf, dp, 8'h00, 1'b0, 3'd0, op, 1'b0, 5'd0);
  endtask
  task automatic e_drop(input string tag, input logic [2:0] g, input logic [7:0] op);
    exp_rec(tag, g, op, 2'd0, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0, op, 1'b1, 5'd4);
  endtask
  task automatic e_cb(input string tag, input logic [7:0] op, input logic sl);
    exp_rec(tag, 3'd1, op, 2'd0, 1'b0, 1'b0, 8'h00, sl, 3'd0, op, 1'b0, 5'd0);
  endtask
  task automatic e_ed(input string tag, input logic [7:0] op, input logic [2:0] k,
                      input logic [7:0] cn, input logic [T_W-1:0] ft);
    exp_rec(tag, 3'd2, op, 2'd0, 1'b0, 1'b0, 8'h00, 1'b0, k, cn, 1'b0, ft);
  endtask
  task automatic e_xcb(input string tag, input logic [2:0] g, input logic [7:0] op,
                       input logic [1:0] sel, input logic [7:0] db, input logic sl);
    exp_rec(tag, g, op, sel, 1'b0, 1'b1, db, sl, 3'd0, op, 1'b0, 5'd0);
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    byte_valid = 1'b1;
    byte_data  = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      byte_valid = 1'b0;
    end
  endtask

  task automatic check_bit(input string tag, input logic act, input logic expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, expv);
    end
  endtask

  // monitor: compare each record with the front of the scoreboard
  always @(negedge clk) begin
    if (!rst && rec_valid) begin
      logic [REC_W-1:0] act;
      act = {rec_group, rec_opcode, rec_sel, rec_half, rec_disp, rec_disp_byte,
             rec_sll, rec_edkind, rec_canon, rec_dropped, rec_fixed_t};
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected record: got %h expected none", act);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (act !== e.v) begin
          errors++;
          $display("FAIL %s: got %h expected %h", e.tag, act, e.v);
        end
      end
    end
  end

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        check_bit("R1 valid low in reset", rec_valid, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check_bit("R1 valid low after reset", rec_valid, 1'b0);

        // R2 plain bytes
        put(8'h00); e_none("R2 op00", 8'h00);
        put(8'h3E); e_none("R2 op3E", 8'h3E);
        put(8'h76); e_none("R2 op76", 8'h76);

        // R14 unstrobed prefix values are ignored
        @(negedge clk); byte_valid = 1'b0; byte_data = 8'hDD;
        @(negedge clk); byte_data = 8'hED;
        put(8'h21); e_none("R14 strobe-less DD/ED ignored", 8'h21);
        idle(1);

        // R3 pair substitution
        put(8'hDD); put(8'h21); e_idx("R3 DD21", 3'd3, 8'h21, 2'd1, 1'b0, 1'b0);
        put(8'hFD); put(8'hE9); e_idx("R3 FDE9", 3'd4, 8'hE9, 2'd2, 1'b0, 1'b0);
        put(8'hDD); put(8'h09); e_idx("R3 DD09", 3'd3, 8'h09, 2'd1, 1'b0, 1'b0);
        put(8'hFD); put(8'hF9); e_idx("R3 FDF9", 3'd4, 8'hF9, 2'd2, 1'b0, 1'b0);

        // R4 memory through HL
        put(8'hDD); put(8'h7E); e_idx("R4 DD7E", 3'd3, 8'h7E, 2'd1, 1'b0, 1'b1);
        put(8'hFD); put(8'h36); e_idx("R4 FD36", 3'd4, 8'h36, 2'd2, 1'b0, 1'b1);
        put(8'hDD); put(8'h86); e_idx("R4 DD86", 3'd3, 8'h86, 2'd1, 1'b0, 1'b1);
        put(8'hDD); put(8'h76); e_idx("R4 DD76 halt", 3'd3, 8'h76, 2'd0, 1'b0, 1'b0);

        // R5 halves
        put(8'hFD); put(8'h44); e_idx("R5 FD44", 3'd4, 8'h44, 2'd2, 1'b1, 1'b0);
        put(8'hDD); put(8'h26); e_idx("R5 DD26", 3'd3, 8'h26, 2'd1, 1'b1, 1'b0);
        put(8'hDD); put(8'h66); e_idx("R5 DD66 mem keeps H", 3'd3, 8'h66, 2'd1, 1'b0, 1'b1);
        put(8'hFD); put(8'hA5); e_idx("R5 FDA5", 3'd4, 8'hA5, 2'd2, 1'b1, 1'b0);

        // R6 unrelated opcodes
        put(8'hDD); put(8'h00); e_idx("R6 DD00", 3'd3, 8'h00, 2'd0, 1'b0, 1'b0);
        put(8'hDD); put(8'hEB); e_idx("R6 DDEB", 3'd3, 8'hEB, 2'd0, 1'b0, 1'b0);
        put(8'hFD); put(8'h41); e_idx("R6 FD41", 3'd4, 8'h41, 2'd0, 1'b0, 1'b0);

        // R7 chained index prefixes
        put(8'hDD); put(8'hFD); e_drop("R7 drop DD", 3'd3, 8'hDD);
        put(8'hDD); e_drop("R7 drop FD", 3'd4, 8'hFD);
        put(8'h21); e_idx("R7 last prefix wins", 3'd3, 8'h21, 2'd1, 1'b0, 1'b0);

        // R8 prefix of another kind
        put(8'hDD); put(8'hED); e_drop("R8 DD before ED", 3'd3, 8'hDD);
        put(8'h44); e_ed("R8 ED44 after drop", 8'h44, 3'd1, 8'h44, 5'd0);
        put(8'hED); put(8'hFD); e_drop("R8 ED before FD", 3'd2, 8'hED);
        put(8'h21); e_idx("R8 FD21 after drop", 3'd4, 8'h21, 2'd2, 1'b0, 1'b0);

        // R9 doubly prefixed forms
        put(8'hDD); put(8'hCB); put(8'h05); put(8'h06);
        e_xcb("R9 DDCB 05 06", 3'd5, 8'h06, 2'd1, 8'h05, 1'b0);
        put(8'hFD); put(8'hCB); put(8'hFE); put(8'h36);
        e_xcb("R9 R10 FDCB FE 36", 3'd6, 8'h36, 2'd2, 8'hFE, 1'b1);

        // R10 shift-left-set-bit-0
        put(8'hCB); put(8'h30); e_cb("R10 CB30", 8'h30, 1'b1);
        put(8'hCB); put(8'h37); e_cb("R10 CB37", 8'h37, 1'b1);
        put(8'hCB); put(8'h38); e_cb("R10 CB38", 8'h38, 1'b0);
        put(8'hCB); put(8'h2F); e_cb("R10 CB2F", 8'h2F, 1'b0);
        put(8'hCB); put(8'hDD); e_cb("R10 CBDD plain", 8'hDD, 1'b0);

        // R11 undefined ED outside 40-7F
        put(8'hED); put(8'h00); e_ed("R11 ED00", 8'h00, 3'd2, 8'h00, 5'd8);
        put(8'hED); put(8'hFF); e_ed("R11 EDFF", 8'hFF, 3'd2, 8'h00, 5'd8);
        put(8'hED); put(8'hA4); e_ed("R11 EDA4", 8'hA4, 3'd2, 8'h00, 5'd8);
        put(8'hED); put(8'hA0); e_ed("R11 EDA0 block", 8'hA0, 3'd1, 8'hA0, 5'd0);
        put(8'hED); put(8'hBB); e_ed("R11 EDBB block", 8'hBB, 3'd1, 8'hBB, 5'd0);

        // R12 aliases
        put(8'hED); put(8'h4C); e_ed("R12 ED4C", 8'h4C, 3'd3, 8'h44, 5'd0);
        put(8'hED); put(8'h7C); e_ed("R12 ED7C", 8'h7C, 3'd3, 8'h44, 5'd0);
        put(8'hED); put(8'h55); e_ed("R12 ED55", 8'h55, 3'd3, 8'h45, 5'd0);
        put(8'hED); put(8'h7D); e_ed("R12 ED7D", 8'h7D, 3'd3, 8'h45, 5'd0);
        put(8'hED); put(8'h4D); e_ed("R12 ED4D defined", 8'h4D, 3'd1, 8'h4D, 5'd0);
        put(8'hED); put(8'h66); e_ed("R12 ED66", 8'h66, 3'd3, 8'h46, 5'd0);
        put(8'hED); put(8'h76); e_ed("R12 ED76", 8'h76, 3'd3, 8'h56, 5'd0);
        put(8'hED); put(8'h7E); e_ed("R12 ED7E", 8'h7E, 3'd3, 8'h5E, 5'd0);

        // R13 port specials and 77/7F
        put(8'hED); put(8'h70); e_ed("R13 ED70", 8'h70, 3'd4, 8'h70, 5'd0);
        put(8'hED); put(8'h71); e_ed("R13 ED71", 8'h71, 3'd5, 8'h71, 5'd0);
        put(8'hED); put(8'h77); e_ed("R13 ED77", 8'h77, 3'd2, 8'h00, 5'd8);
        put(8'hED); put(8'h7F); e_ed("R13 ED7F", 8'h7F, 3'd2, 8'h00, 5'd8);
        idle(3);

        // R1 reset drops a pending prefix
        put(8'hDD);
        @(negedge clk); byte_valid = 1'b0; rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        put(8'h21); e_none("R1 prefix cleared by reset", 8'h21);
        idle(4);

        checks++;
        if (exp_q.size() != 0) begin
          errors++;
          $display("FAIL R2 missing records: got %0d pending expected 0", exp_q.size());
        end
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule